// File: doc/BRIEF.md
# Fractional Rate-Normalizing Free-Running Counter

This block keeps a 64-bit tick count that advances at one fixed nominal rate, 6.144 MHz, whatever the frequency of the reference clock that drives it. On every reference cycle it adds a programmable numerator to a fractional accumulator. Each time the accumulator reaches the programmable denominator, the denominator is taken off and the count steps by one. Software picks the ratio so that the reference frequency times numerator/denominator comes to 6.144 MHz. Some examples: 4/25 for 38.4 MHz (the reset default), 8/25 for 19.2 MHz, 64/125 for 12 MHz, 768/1625 for 13 MHz, 384/1625 for 26 MHz and 256/1125 for 27 MHz.

A small register port reads and writes the two ratio registers and reads the count. The count is 64 bits wide and is read as two 32-bit words. A read of the low word also captures the high word, so the two halves form one coherent value. The count is also driven out in full on its own port for consumers that sit next to the block.

Top module: `frac_rate_counter`

## Requirements
- R1: After reset the count is 0, the accumulator is 0, the numerator register reads 4 and the denominator register reads 25.
- R2: When the numerator (low 12 bits) is below a nonzero denominator (low 12 bits), each cycle adds the numerator to the accumulator. When the sum is at least the denominator, the denominator is subtracted and the count rises by one. Starting from a clear accumulator, N cycles therefore give floor(N*num/den) counts.
- R3: The count rises by at most one per cycle. When the numerator is at least a nonzero denominator, the count rises by exactly one every cycle and the accumulator stays clear.
- R4: A denominator of zero disables counting: the count holds and the accumulator is cleared.
- R5: A write to either ratio register clears the accumulator, and the count does not advance in that cycle. The new ratio applies from the next cycle on.
- R6: Each ratio register stores all 32 written bits and reads them back unchanged. Only the low 12 bits take part in counting.
- R7: The byte addresses are 0x00 (count bits 31:0), 0x04 (count bits 63:32 snapshot), 0x10 (numerator) and 0x14 (denominator). Read data appears on rdata the cycle after rd_en and holds until the next read. Any other address reads 0. Writes to the count addresses or to unmapped addresses change nothing.
- R8: A read of address 0x00 captures count bits 63:32 in a snapshot. Reads of 0x04 return that snapshot, which is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| count | output | 64 | Live free-running count |

## Verification
The hardest case to reach is a ratio write that lands on the exact cycle in which the accumulator would have wrapped. The wrap must be lost, with no count step in that cycle, and the phase must restart from zero under the new ratio. To hit it, the stimulus issues writes of the standard ratios, of ratios at or above one and of a zero denominator at random cycles over several thousand cycles. A reference model in the bench follows every accumulator phase and compares the count on every cycle, so writes fall on wrap cycles many times. Directed steps add exact counts over a known window, the disabled state and read-back of the upper register bits.

// File: rtl/frc_pkg.sv
package frc_pkg;
    localparam logic [7:0] OFF_CNT_LO = 8'h00;
    localparam logic [7:0] OFF_CNT_HI = 8'h04;
    localparam logic [7:0] OFF_NUM    = 8'h10;
    localparam logic [7:0] OFF_DEN    = 8'h14;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CNT_LO,
        SEL_CNT_HI,
        SEL_NUM,
        SEL_DEN
    } frc_sel_e;

    function automatic frc_sel_e frc_decode(input logic [7:0] a);
        case (a)
            OFF_CNT_LO: return SEL_CNT_LO;
            OFF_CNT_HI: return SEL_CNT_HI;
            OFF_NUM:    return SEL_NUM;
            OFF_DEN:    return SEL_DEN;
            default:    return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/frc_regs.sv
module frc_regs
    import frc_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int DEF_NUM = 4,
    parameter int DEF_DEN = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] num_reg,
    output logic [DATA_W-1:0] den_reg,
    output logic              ratio_wr
);
    typedef struct packed {
        logic [DATA_W-1:0] num;
        logic [DATA_W-1:0] den;
    } regs_s;

    localparam logic [DATA_W-1:0] RST_NUM = DATA_W'(DEF_NUM);
    localparam logic [DATA_W-1:0] RST_DEN = DATA_W'(DEF_DEN);

    regs_s    r_d, r_q;
    frc_sel_e sel;

    always_comb begin
        sel      = frc_decode(8'(addr));
        r_d      = r_q;
        ratio_wr = 1'b0;
        if (wr_en) begin
            if (sel == SEL_NUM) begin
                r_d.num  = wdata;
                ratio_wr = 1'b1;
            end else if (sel == SEL_DEN) begin
                r_d.den  = wdata;
                ratio_wr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.num <= RST_NUM;
            r_q.den <= RST_DEN;
        end else begin
            r_q <= r_d;
        end
    end

    assign num_reg = r_q.num;
    assign den_reg = r_q.den;

    // R6
    num_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_NUM)) |=> num_reg == $past(wdata));

    // R6
    den_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_DEN)) |=> den_reg == $past(wdata));
endmodule

// File: rtl/frc_accum.sv
module frc_accum #(
    parameter int FRAC_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FRAC_W-1:0] num,
    input  logic [FRAC_W-1:0] den,
    input  logic              clr,
    output logic              step
);
    typedef struct packed {
        logic [FRAC_W-1:0] acc;
    } acc_s;

    acc_s            a_d, a_q;
    logic [FRAC_W:0] sum;
    logic [FRAC_W:0] rem;

    always_comb begin
        sum  = {1'b0, a_q.acc} + {1'b0, num};
        rem  = sum - {1'b0, den};
        a_d  = a_q;
        step = 1'b0;
        if (clr || den == '0) begin
            a_d.acc = '0;
        end else if (num >= den) begin
            a_d.acc = '0;
            step    = 1'b1;
        end else if (sum >= {1'b0, den}) begin
            a_d.acc = rem[FRAC_W-1:0];
            step    = 1'b1;
        end else begin
            a_d.acc = sum[FRAC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    // R2
    acc_below_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (den != '0) |-> (a_q.acc < den));

    // R5
    clr_zeroes_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (a_q.acc == '0));

    // R4
    den_zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (den == '0) |=> (a_q.acc == '0));
endmodule

// File: rtl/frc_count.sv
module frc_count
    import frc_pkg::*;
#(
    parameter int COUNT_W = 64,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  num_reg,
    input  logic [DATA_W-1:0]  den_reg,
    output logic [COUNT_W-1:0] count,
    output logic [DATA_W-1:0]  rdata
);
    localparam int SNAP_W = COUNT_W - DATA_W;

    typedef struct packed {
        logic [COUNT_W-1:0] cnt;
        logic [SNAP_W-1:0]  snap;
        logic [DATA_W-1:0]  rdata;
    } cnt_s;

    cnt_s     c_d, c_q;
    frc_sel_e sel;

    always_comb begin
        sel = frc_decode(8'(addr));
        c_d = c_q;
        if (step) c_d.cnt = c_q.cnt + COUNT_W'(1);
        if (rd_en) begin
            case (sel)
                SEL_CNT_LO: begin
                    c_d.rdata = c_q.cnt[DATA_W-1:0];
                    c_d.snap  = c_q.cnt[COUNT_W-1:DATA_W];
                end
                SEL_CNT_HI: c_d.rdata = DATA_W'(c_q.snap);
                SEL_NUM:    c_d.rdata = num_reg;
                SEL_DEN:    c_d.rdata = den_reg;
                default:    c_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign count = c_q.cnt;
    assign rdata = c_q.rdata;

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == $past(count)) || (count == $past(count) + COUNT_W'(1)));

    // R8
    snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(OFF_CNT_LO)) |=> c_q.snap == $past(count[COUNT_W-1:DATA_W]));
endmodule

// File: rtl/frac_rate_counter.sv
module frac_rate_counter #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int FRAC_W  = 12,
    parameter int COUNT_W = 64,
    parameter int DEF_NUM = 4,
    parameter int DEF_DEN = 25
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic [COUNT_W-1:0] count
);
    logic [DATA_W-1:0] num_reg;
    logic [DATA_W-1:0] den_reg;
    logic              ratio_wr;
    logic              step;

    frc_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEF_NUM(DEF_NUM),
        .DEF_DEN(DEF_DEN)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .num_reg (num_reg),
        .den_reg (den_reg),
        .ratio_wr(ratio_wr)
    );

    frc_accum #(
        .FRAC_W(FRAC_W)
    ) u_accum (
        .clk  (clk),
        .rst_n(rst_n),
        .num  (num_reg[FRAC_W-1:0]),
        .den  (den_reg[FRAC_W-1:0]),
        .clr  (ratio_wr),
        .step (step)
    );

    frc_count #(
        .COUNT_W(COUNT_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .rd_en  (rd_en),
        .addr   (addr),
        .num_reg(num_reg),
        .den_reg(den_reg),
        .count  (count),
        .rdata  (rdata)
    );

    // R4
    den_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (den_reg[FRAC_W-1:0] == '0) |=> $stable(count));

    // R5
    wr_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_wr |=> $stable(count));

    // R3
    full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ratio_wr && den_reg[FRAC_W-1:0] != '0 && num_reg[FRAC_W-1:0] >= den_reg[FRAC_W-1:0])
        |=> count == $past(count) + COUNT_W'(1));
endmodule

// File: tb/frac_rate_counter_test.sv
module frac_rate_counter_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] count;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    logic [63:0] m_cnt;
    logic [31:0] m_num, m_den, m_rdata, m_snap;
    int unsigned m_acc;

    always #(CLK_PERIOD/2) clk = ~clk;

    frac_rate_counter uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .count(count)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_acc = 0; m_num = 32'd4; m_den = 32'd25;
            m_rdata = 0; m_snap = 0;
        end else begin
            int unsigned n12, d12, s;
            if (rd_en) begin
                case (addr)
                    8'h00: begin m_rdata = m_cnt[31:0]; m_snap = m_cnt[63:32]; end
                    8'h04: m_rdata = m_snap;
                    8'h10: m_rdata = m_num;
                    8'h14: m_rdata = m_den;
                    default: m_rdata = 0;
                endcase
            end
            n12 = m_num[11:0];
            d12 = m_den[11:0];
            if (wr_en && (addr == 8'h10 || addr == 8'h14)) begin
                if (addr == 8'h10) m_num = wdata; else m_den = wdata;
                m_acc = 0;
            end else if (d12 == 0) begin
                m_acc = 0;
            end else if (n12 >= d12) begin
                m_acc = 0; m_cnt = m_cnt + 1;
            end else begin
                s = m_acc + n12;
                if (s >= d12) begin m_acc = s - d12; m_cnt = m_cnt + 1; end
                else m_acc = s;
            end
        end
    end

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R2: the live count is compared with the model every cycle
    task automatic tick();
        @(negedge clk);
        check64("R2 count", count, m_cnt);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        rd_en = 1'b1; addr = a;
        tick();
        rd_en = 1'b0;
        check64(req, {32'd0, rdata}, {32'd0, m_rdata});
    endtask

    function automatic logic [11:0] std_num(input int i);
        case (i)
            0: return 12'd8;   1: return 12'd4;   2: return 12'd384;
            3: return 12'd256; 4: return 12'd64;  default: return 12'd768;
        endcase
    endfunction

    function automatic logic [11:0] std_den(input int i);
        case (i)
            0: return 12'd25;   1: return 12'd25;  2: return 12'd1625;
            3: return 12'd1125; 4: return 12'd125; default: return 12'd1625;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] c0;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: reset state
        check64("R1 count at reset", count, 64'd0);
        rst_n = 1'b1;
        // R2: default 4/25 over 250 cycles gives exactly 40
        repeat (250) tick();
        check64("R2 default ratio 250 cycles", count, 64'd40);
        // R1: reset values of the ratio registers
        rd(8'h10, "R1 numerator reset");
        check64("R1 numerator value", {32'd0, rdata}, 64'd4);
        rd(8'h14, "R1 denominator reset");
        check64("R1 denominator value", {32'd0, rdata}, 64'd25);
        // R8: high word snapshot is 0 before any low read
        rd(8'h04, "R8 snapshot at reset");
        check64("R8 snapshot value", {32'd0, rdata}, 64'd0);
        rd(8'h00, "R8 low word read");
        rd(8'h04, "R8 snapshot after low read");
        // R6: upper bits stored and read back
        wr(8'h10, 32'hABCDE008);
        rd(8'h10, "R6 numerator upper bits");
        check64("R6 numerator value", {32'd0, rdata}, 64'h00000000ABCDE008);
        wr(8'h14, 32'h5A5A5019);
        rd(8'h14, "R6 denominator upper bits");
        check64("R6 denominator value", {32'd0, rdata}, 64'h000000005A5A5019);
        // R2: 8/25 from a clear phase, 100 cycles -> 32
        c0 = count;
        repeat (100) tick();
        check64("R2 ratio 8/25 100 cycles", count - c0, 64'd32);
        // R7: write to count address is ignored, unmapped reads 0
        c0 = count;
        wr(8'h00, 32'hFFFFFFFF);
        wr(8'h04, 32'hFFFFFFFF);
        check64("R7 count write ignored", count, m_cnt);
        rd(8'h08, "R7 unmapped read");
        check64("R7 unmapped value", {32'd0, rdata}, 64'd0);
        // R4: zero denominator holds the count
        wr(8'h14, 32'd0);
        c0 = count;
        repeat (20) tick();
        check64("R4 disabled count holds", count, c0);
        // R3: numerator at or above denominator counts every cycle
        wr(8'h14, 32'd25);
        wr(8'h10, 32'd30);
        c0 = count;
        repeat (10) tick();
        check64("R3 full rate", count - c0, 64'd10);
        // R5: ratio write cycle does not advance the count
        c0 = count;
        wr(8'h10, 32'd30);
        check64("R5 no step on write", count, c0);
        // R5: 13 MHz ratio, phase restarts, 1625 cycles -> 768
        wr(8'h14, 32'd1625);
        wr(8'h10, 32'd768);
        c0 = count;
        repeat (1625) tick();
        check64("R5 clean phase 768/1625", count - c0, 64'd768);
        // random mix with writes at random phases
        for (int i = 0; i < 6000; i++) begin
            int op;
            op = int'($urandom % 20);
            if (op == 0) begin
                int k; k = int'($urandom % 6);
                wr(8'h14, {$urandom % 32'h100000, std_den(k)});
                wr(8'h10, {$urandom % 32'h100000, std_num(k)});
            end else if (op == 1) begin
                wr(8'h10, {20'd0, 12'($urandom % 40)});
            end else if (op == 2) begin
                wr(8'h14, {20'd0, 12'($urandom % 30)});
            end else if (op == 3) begin
                logic [7:0] a;
                case ($urandom % 5)
                    0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h10; 3: a = 8'h14; default: a = 8'h0C;
                endcase
                rd(a, "R7 random read");
            end else begin
                tick();
            end
        end
        rd(8'h00, "R8 final low read");
        rd(8'h04, "R8 final snapshot read");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule